// File: doc/BRIEF.md
# Endian-Aware Byte-Lane Steering Unit

This unit sits between a processor's memory port and a 32-bit external data bus. The processor does not supply per-byte strobes. For each transfer it gives a width code, the low bits of the byte address, a load/store direction and a signed/unsigned choice. The unit works out which byte lanes of the bus take part. For stores it moves the register-justified write data onto those lanes. For loads it takes the addressed bytes from the bus word, right-justifies them and zero- or sign-extends them to 32 bits.

The lane order depends on the effective endianness. The base endianness comes from a strap input, which is captured only while reset is asserted. A reverse-endian control bit inverts the base order, but only while the processor is in user mode. A halfword at an odd offset, or a word at a nonzero offset, is not carried out: it is flagged as misaligned. The reserved three-byte width code is flagged as a bad width.

Requests arrive on a valid/ready channel and results leave on a second valid/ready channel, with one register stage between them. A request is accepted when `req_valid` and `req_ready` are both high. `req_ready` is high whenever the output stage is empty or its content is being taken in the same cycle. While `rsp_valid` is high and `rsp_ready` is low, every response output holds its value and no new request is accepted. Load data on `bus_rdata` is sampled together with the request.

Top module: `endian_lane_steer`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rsp_valid`, `rsp_be`, `rsp_wdata`, `rsp_rdata`, `rsp_misalign` and `rsp_badwidth` are all zero.
- R2: A request accepted at a clock edge appears on the response outputs, with `rsp_valid` high, after exactly that one edge.
- R3: While `rsp_valid` is high and `rsp_ready` is low, `req_ready` is low and every response output keeps its value.
- R4: In little-endian order, lane k carries bus bits 8k+7:8k. A byte at offset k enables lane k, and a halfword at offset 0 or 2 enables lanes {off, off+1}. Width codes: 00 is byte, 01 is halfword, 10 is reserved, 11 is word.
- R5: In big-endian order, a byte at offset k enables lane 3-k, so offset 0 uses bits 31:24. A halfword at offset 0 enables lanes {2,3}, and at offset 2 it enables lanes {0,1}.
- R6: A word at offset 0 enables all four lanes (`rsp_be` = 1111). It passes store data and load data unchanged in either order.
- R7: For a store, the lowest 8·n bits of `req_wdata` (n = transfer size in bytes) appear on the enabled lanes, with the value's least significant byte on the lowest enabled lane. Disabled lanes are zero and `rsp_rdata` is zero.
- R8: For a load, the enabled lanes of `bus_rdata` are returned right-justified in `rsp_rdata`. The upper bits copy the top bit of the extracted value when `req_signed` is 1, and are zero when it is 0. `rsp_wdata` is zero.
- R9: A halfword at an odd offset, or a word at a nonzero offset, sets `rsp_misalign`. It drives `rsp_be` to 0000 and both data outputs to zero.
- R10: Width code 10 sets `rsp_badwidth`. It drives `rsp_be` to 0000 and both data outputs to zero. The two flags are never set together.
- R11: The effective order is the inverse of the base order when `user_mode` and `rev_endian` are both 1. Otherwise it is the base order, so `rev_endian` has no effect in kernel mode.
- R12: The base order is taken from `strap_big_endian` (1 = big-endian) only while reset is asserted. Changing the strap after reset has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| strap_big_endian | input | 1 | Boot strap for base order, captured during reset |
| user_mode | input | 1 | Processor is in user mode |
| rev_endian | input | 1 | Reverse-endian control bit |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request accepted when high together with req_valid |
| req_width | input | 2 | Width code: 00 byte, 01 half, 10 reserved, 11 word |
| req_off | input | 2 | Byte address bits 1:0 |
| req_load | input | 1 | 1 = load, 0 = store |
| req_signed | input | 1 | 1 = sign-extend load result |
| req_wdata | input | 32 | Register-justified store data |
| bus_rdata | input | 32 | Bus word returned for a load |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Downstream takes the response |
| rsp_be | output | 4 | Byte-lane enables, bit k = lane k (bits 8k+7:8k) |
| rsp_wdata | output | 32 | Store data placed on the bus lanes |
| rsp_rdata | output | 32 | Extended load result |
| rsp_misalign | output | 1 | Misaligned request flag |
| rsp_badwidth | output | 1 | Reserved width code flag |

## Verification
The hardest condition to reach is the reverse-endian override. It needs a particular base order, which can only be set through a reset with the strap held. It also needs the user-mode and control inputs to agree. The vector table therefore carries the base order in each entry, and the bench applies a reset with the strap at that value whenever the base order changes between entries. This covers the override and its kernel-mode non-effect under both base orders. A directed test moves the strap after reset and shows that the lanes do not follow it. A second directed test holds `rsp_ready` low while a new request waits. This shows the stall and the hand-over in the cycle after release.

// File: rtl/lane_steer_pkg.sv
package lane_steer_pkg;
  localparam int BUS_W  = 32;
  localparam int LANES  = BUS_W / 8;
  localparam int OFF_W  = $clog2(LANES);
  localparam int CNT_W  = OFF_W + 1;

  typedef enum logic [1:0] {
    XW_BYTE   = 2'b00,
    XW_HALF   = 2'b01,
    XW_TRIPLE = 2'b10,
    XW_WORD   = 2'b11
  } xfer_width_e;
endpackage

// File: rtl/endian_mode.sv
module endian_mode (
  input  logic clk,
  input  logic rst,
  input  logic strap_big,
  input  logic user_mode,
  input  logic rev_bit,
  output logic eff_big
);
  logic base_big_q;

  // The strap is sampled only while reset is held; afterwards it is ignored.
  always_ff @(posedge clk) begin
    if (rst) base_big_q <= strap_big;
  end

  assign eff_big = base_big_q ^ (user_mode & rev_bit);
endmodule

// File: rtl/lane_decode.sv
module lane_decode
  import lane_steer_pkg::*;
(
  input  logic [1:0]       width,
  input  logic [OFF_W-1:0] off,
  input  logic             big,
  output logic [LANES-1:0] be,
  output logic [OFF_W-1:0] low_lane,
  output logic [CNT_W-1:0] nbytes,
  output logic             misalign,
  output logic             badwidth
);
  logic [LANES-1:0] span;
  logic [CNT_W:0]   low_calc;

  always_comb begin
    nbytes   = CNT_W'(width) + CNT_W'(1);
    badwidth = (width == XW_TRIPLE);
    misalign = ((width == XW_HALF) && off[0]) ||
               ((width == XW_WORD) && (off != '0));
    span     = LANES'((1 << nbytes) - 1);
    if (big) low_calc = (CNT_W+1)'(LANES) - (CNT_W+1)'(off) - (CNT_W+1)'(nbytes);
    else     low_calc = (CNT_W+1)'(off);
    low_lane = low_calc[OFF_W-1:0];
    if (misalign || badwidth) be = '0;
    else                      be = span << low_lane;
  end
endmodule

// File: rtl/store_steer.sv
module store_steer
  import lane_steer_pkg::*;
(
  input  logic [BUS_W-1:0] din,
  input  logic [OFF_W-1:0] low_lane,
  input  logic [LANES-1:0] be,
  output logic [BUS_W-1:0] dout
);
  logic [BUS_W-1:0] shifted;
  assign shifted = din << {low_lane, 3'b000};

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign dout[8*j +: 8] = be[j] ? shifted[8*j +: 8] : 8'h00;
  end
endmodule

// File: rtl/load_extract.sv
module load_extract
  import lane_steer_pkg::*;
(
  input  logic [BUS_W-1:0] rdin,
  input  logic [OFF_W-1:0] low_lane,
  input  logic [CNT_W-1:0] nbytes,
  input  logic             sgn,
  output logic [BUS_W-1:0] dout
);
  logic [BUS_W-1:0] justified;
  logic             top_bit;
  logic [7:0]       fill;

  assign justified = rdin >> {low_lane, 3'b000};

  always_comb begin
    top_bit = 1'b0;
    for (int k = 1; k <= LANES; k++) begin
      if (nbytes == CNT_W'(k)) top_bit = justified[8*k-1];
    end
  end

  assign fill = (sgn && top_bit) ? 8'hFF : 8'h00;

  for (genvar j = 0; j < LANES; j++) begin : g_lane
    assign dout[8*j +: 8] = (CNT_W'(j) < nbytes) ? justified[8*j +: 8] : fill;
  end
endmodule

// File: rtl/endian_lane_steer.sv
module endian_lane_steer
  import lane_steer_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             strap_big_endian,
  input  logic             user_mode,
  input  logic             rev_endian,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_width,
  input  logic [1:0]       req_off,
  input  logic             req_load,
  input  logic             req_signed,
  input  logic [31:0]      req_wdata,
  input  logic [31:0]      bus_rdata,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic [3:0]       rsp_be,
  output logic [31:0]      rsp_wdata,
  output logic [31:0]      rsp_rdata,
  output logic             rsp_misalign,
  output logic             rsp_badwidth
);
  logic             eff_big;
  logic [LANES-1:0] be_c;
  logic [OFF_W-1:0] low_c;
  logic [CNT_W-1:0] nb_c;
  logic             mis_c, bad_c, ok_c;
  logic [BUS_W-1:0] st_c, ld_c;

  endian_mode u_mode (
    .clk(clk), .rst(rst), .strap_big(strap_big_endian),
    .user_mode(user_mode), .rev_bit(rev_endian), .eff_big(eff_big)
  );

  lane_decode u_dec (
    .width(req_width), .off(req_off), .big(eff_big), .be(be_c),
    .low_lane(low_c), .nbytes(nb_c), .misalign(mis_c), .badwidth(bad_c)
  );

  store_steer u_st (
    .din(req_wdata), .low_lane(low_c), .be(be_c), .dout(st_c)
  );

  load_extract u_ld (
    .rdin(bus_rdata), .low_lane(low_c), .nbytes(nb_c),
    .sgn(req_signed), .dout(ld_c)
  );

  assign ok_c      = !mis_c && !bad_c;
  assign req_ready = !rsp_valid || rsp_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_be       <= '0;
      rsp_wdata    <= '0;
      rsp_rdata    <= '0;
      rsp_misalign <= 1'b0;
      rsp_badwidth <= 1'b0;
    end else if (req_ready) begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_be       <= be_c;
        rsp_wdata    <= (ok_c && !req_load) ? st_c : '0;
        rsp_rdata    <= (ok_c &&  req_load) ? ld_c : '0;
        rsp_misalign <= mis_c;
        rsp_badwidth <= bad_c;
      end
    end
  end
endmodule

// File: rtl/lane_steer_chk.sv
module lane_steer_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic        rsp_valid,
  input logic        rsp_ready,
  input logic [3:0]  rsp_be,
  input logic [31:0] rsp_wdata,
  input logic [31:0] rsp_rdata,
  input logic        rsp_misalign,
  input logic        rsp_badwidth
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!rsp_valid && rsp_be == 4'h0 && !rsp_misalign && !rsp_badwidth));

  // R2
  one_cycle_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> rsp_valid);

  // R3
  stall_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |-> !req_ready);

  // R3
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_be) && $stable(rsp_wdata)
      && $stable(rsp_rdata) && $stable(rsp_misalign) && $stable(rsp_badwidth)));

  // R9
  misalign_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_misalign) |-> (rsp_be == 4'h0 && rsp_wdata == 32'h0 && rsp_rdata == 32'h0));

  // R10
  badwidth_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_badwidth) |-> (rsp_be == 4'h0 && !rsp_misalign));

  // R4
  lane_count_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_misalign && !rsp_badwidth) |->
      ($countones(rsp_be) == 1 || $countones(rsp_be) == 2 || $countones(rsp_be) == 4));
endmodule

bind endian_lane_steer lane_steer_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_be(rsp_be),
  .rsp_wdata(rsp_wdata), .rsp_rdata(rsp_rdata),
  .rsp_misalign(rsp_misalign), .rsp_badwidth(rsp_badwidth)
);

// File: tb/tb_endian_lane_steer.sv
module tb_endian_lane_steer;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic strap_big_endian = 1'b0, user_mode = 1'b0, rev_endian = 1'b0;
  logic req_valid = 1'b0, req_load = 1'b0, req_signed = 1'b0, rsp_ready = 1'b1;
  logic [1:0] req_width = 2'b00, req_off = 2'b00;
  logic [31:0] req_wdata = 32'h0, bus_rdata = 32'h0;
  logic req_ready, rsp_valid, rsp_misalign, rsp_badwidth;
  logic [3:0] rsp_be;
  logic [31:0] rsp_wdata, rsp_rdata;

  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  endian_lane_steer dut (.*);

  // {base, user, rev, width, off, load, signed, din, exp_be, exp_data, exp_mis, exp_bad, req}
  typedef struct packed {
    logic base, usr, rev;
    logic [1:0] wid, off;
    logic ld, sg;
    logic [31:0] din;
    logic [3:0] ebe;
    logic [31:0] edat;
    logic emis, ebad;
    logic [3:0] rq;
  } vec_t;

  localparam logic [31:0] D = 32'hA1B2C3D4;
  localparam int NV = 30;
  localparam vec_t VEC [NV] = '{
    // little-endian base: R4, R7, R8, R6, R9, R10, R11
    {1'b0,1'b0,1'b0,2'b00,2'd0,1'b0,1'b0,D,4'b0001,32'h000000D4,1'b0,1'b0,4'd4},
    {1'b0,1'b0,1'b0,2'b00,2'd2,1'b0,1'b0,D,4'b0100,32'h00D40000,1'b0,1'b0,4'd7},
    {1'b0,1'b0,1'b0,2'b01,2'd2,1'b0,1'b0,D,4'b1100,32'hC3D40000,1'b0,1'b0,4'd7},
    {1'b0,1'b0,1'b0,2'b11,2'd0,1'b0,1'b0,D,4'b1111,D,1'b0,1'b0,4'd6},
    {1'b0,1'b0,1'b0,2'b00,2'd3,1'b1,1'b0,D,4'b1000,32'h000000A1,1'b0,1'b0,4'd8},
    {1'b0,1'b0,1'b0,2'b00,2'd3,1'b1,1'b1,D,4'b1000,32'hFFFFFFA1,1'b0,1'b0,4'd8},
    {1'b0,1'b0,1'b0,2'b01,2'd0,1'b1,1'b1,D,4'b0011,32'hFFFFC3D4,1'b0,1'b0,4'd8},
    {1'b0,1'b0,1'b0,2'b01,2'd2,1'b1,1'b0,D,4'b1100,32'h0000A1B2,1'b0,1'b0,4'd8},
    {1'b0,1'b0,1'b0,2'b00,2'd1,1'b1,1'b1,D,4'b0010,32'hFFFFFFC3,1'b0,1'b0,4'd8},
    {1'b0,1'b0,1'b0,2'b00,2'd0,1'b1,1'b1,32'h0000007F,4'b0001,32'h0000007F,1'b0,1'b0,4'd8},
    {1'b0,1'b0,1'b0,2'b01,2'd1,1'b0,1'b0,D,4'b0000,32'h0,1'b1,1'b0,4'd9},
    {1'b0,1'b0,1'b0,2'b11,2'd2,1'b1,1'b0,D,4'b0000,32'h0,1'b1,1'b0,4'd9},
    {1'b0,1'b0,1'b0,2'b10,2'd0,1'b0,1'b0,D,4'b0000,32'h0,1'b0,1'b1,4'd10},
    {1'b0,1'b1,1'b1,2'b00,2'd0,1'b0,1'b0,D,4'b1000,32'hD4000000,1'b0,1'b0,4'd11},
    {1'b0,1'b0,1'b1,2'b00,2'd0,1'b0,1'b0,D,4'b0001,32'h000000D4,1'b0,1'b0,4'd11},
    {1'b0,1'b1,1'b0,2'b00,2'd1,1'b0,1'b0,D,4'b0010,32'h0000D400,1'b0,1'b0,4'd11},
    // big-endian base: R5, R6, R7, R8, R9, R10, R11
    {1'b1,1'b0,1'b0,2'b00,2'd0,1'b0,1'b0,D,4'b1000,32'hD4000000,1'b0,1'b0,4'd5},
    {1'b1,1'b0,1'b0,2'b00,2'd3,1'b0,1'b0,D,4'b0001,32'h000000D4,1'b0,1'b0,4'd5},
    {1'b1,1'b0,1'b0,2'b01,2'd0,1'b0,1'b0,D,4'b1100,32'hC3D40000,1'b0,1'b0,4'd7},
    {1'b1,1'b0,1'b0,2'b01,2'd2,1'b0,1'b0,D,4'b0011,32'h0000C3D4,1'b0,1'b0,4'd7},
    {1'b1,1'b0,1'b0,2'b11,2'd0,1'b1,1'b1,D,4'b1111,D,1'b0,1'b0,4'd6},
    {1'b1,1'b0,1'b0,2'b11,2'd0,1'b0,1'b0,D,4'b1111,D,1'b0,1'b0,4'd6},
    {1'b1,1'b0,1'b0,2'b00,2'd0,1'b1,1'b1,D,4'b1000,32'hFFFFFFA1,1'b0,1'b0,4'd8},
    {1'b1,1'b0,1'b0,2'b00,2'd2,1'b1,1'b0,D,4'b0010,32'h000000C3,1'b0,1'b0,4'd8},
    {1'b1,1'b0,1'b0,2'b01,2'd2,1'b1,1'b1,D,4'b0011,32'hFFFFC3D4,1'b0,1'b0,4'd8},
    {1'b1,1'b0,1'b0,2'b01,2'd0,1'b1,1'b0,D,4'b1100,32'h0000A1B2,1'b0,1'b0,4'd8},
    {1'b1,1'b0,1'b0,2'b01,2'd3,1'b1,1'b0,D,4'b0000,32'h0,1'b1,1'b0,4'd9},
    {1'b1,1'b1,1'b1,2'b00,2'd0,1'b0,1'b0,D,4'b0001,32'h000000D4,1'b0,1'b0,4'd11},
    {1'b1,1'b0,1'b1,2'b00,2'd0,1'b0,1'b0,D,4'b1000,32'hD4000000,1'b0,1'b0,4'd11},
    {1'b1,1'b0,1'b0,2'b10,2'd1,1'b1,1'b1,D,4'b0000,32'h0,1'b0,1'b1,4'd10}
  };

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    strap_big_endian = strap;
    rst = 1'b1;
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic drive(input vec_t v);
    user_mode = v.usr; rev_endian = v.rev;
    req_width = v.wid; req_off = v.off; req_load = v.ld; req_signed = v.sg;
    req_wdata = v.din; bus_rdata = v.din; req_valid = 1'b1;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    logic cur_base;
    vec_t v, w;
    // R1: reset state, sampled while reset is held
    do_reset(1'b0);
    cur_base = 1'b0;
    check("R1 reset outputs", {31'b0, rsp_valid, rsp_be, rsp_misalign, rsp_badwidth, 26'b0},
          64'h0);
    check("R1 reset data", {rsp_wdata, rsp_rdata}, 64'h0);

    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      if (v.base != cur_base) begin
        do_reset(v.base);
        cur_base = v.base;
      end
      @(negedge clk);
      drive(v);
      @(negedge clk);
      req_valid = 1'b0;
      // R2: response one edge after acceptance
      check($sformatf("R2 valid vec%0d", i), {63'b0, rsp_valid}, 64'h1);
      check($sformatf("R%0d be vec%0d", v.rq, i), {60'b0, rsp_be}, {60'b0, v.ebe});
      check($sformatf("R%0d data vec%0d", v.rq, i),
            {rsp_wdata, rsp_rdata},
            v.ld ? {32'h0, v.edat} : {v.edat, 32'h0});
      check($sformatf("R%0d flags vec%0d", v.rq, i),
            {62'b0, rsp_misalign, rsp_badwidth}, {62'b0, v.emis, v.ebad});
    end

    // R12: strap moved after reset is ignored
    do_reset(1'b0);
    @(negedge clk);
    strap_big_endian = 1'b1;
    v = VEC[0];
    @(negedge clk);
    drive(v);
    @(negedge clk);
    req_valid = 1'b0;
    check("R12 strap after reset", {60'b0, rsp_be}, 64'h1);

    // R3: back-pressure hold and hand-over
    @(negedge clk);
    rsp_ready = 1'b0;
    v = VEC[1];
    drive(v);
    @(negedge clk);
    w = VEC[2];
    drive(w);
    check("R3 ready low in stall", {63'b0, req_ready}, 64'h0);
    @(negedge clk);
    check("R3 be held", {60'b0, rsp_be}, {60'b0, v.ebe});
    check("R3 data held", {32'b0, rsp_wdata}, {32'b0, v.edat});
    rsp_ready = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    check("R3 next after release", {59'b0, rsp_valid, rsp_be}, {59'b0, 1'b1, w.ebe});
    @(negedge clk);
    check("R3 drained", {63'b0, rsp_valid}, 64'h0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule